// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps wall-clock time and a short calendar from a slow oscillator. A strobe arrives on `osc_en` once per oscillator period, which is 32.768 kHz by default, in the system clock domain. A fractional accumulator turns these strobes into a 100 Hz step. Each step moves a packed-BCD chain forward: hundredths, seconds, minutes, hours, day of month and month. The chain also carries a 2-bit year that sets leap Februaries and a 3-bit weekday.

All fields live in a small register file. A bus-side agent reaches it through one address port, with a write strobe and a combinational read path. A control byte stops the chain, selects the operating mode, or freezes the visible counters for a coherent multi-byte read. While the counters are frozen, one step is held in reserve and applied when the freeze ends. The hour byte carries its own 12/24-hour select and AM/PM flag.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the registers read: control 0x00, hundredths 0x00, seconds 0x00, minutes 0x00, hour 0x00, day 0x01 (year 0, day 1) and month 0x01 (weekday 0, January).
- R2: Every `osc_en` strobe adds TICK_HZ to a divider accumulator. When the sum reaches OSC_HZ, OSC_HZ is subtracted and one step is produced. N strobes from a cleared accumulator therefore give floor(N*TICK_HZ/OSC_HZ) steps.
- R3: Address 1 holds hundredths as BCD 00..99. Each step adds one. Leaving 99 wraps to 00 and carries into seconds.
- R4: Seconds (address 2) and minutes (address 3) are BCD 00..59. Each wraps to 00 at 59 and carries into the next field.
- R5: Address 4 holds the hour. Bit 7 set selects 12-hour format and bit 6 is the PM flag. Bits 5:0 hold the BCD hour. In 24-hour format the hour counts 00..23, and leaving 23 wraps to 00 and advances the day.
- R6: In 12-hour format the hour runs 12, 01 .. 11. Passing from 11 to 12 toggles the PM flag. The day advances only when that passage moves from PM to AM.
- R7: Address 5 holds the year in bits 7:6 and the BCD day in bits 5:0. Address 6 holds the weekday in bits 7:5 and the BCD month in bits 4:0. Days run 1 to the month length: 30 for months 4, 6, 9 and 11; for February, 29 when the year is 0 and 28 otherwise; 31 for all other months. The weekday counts 0..6 and wraps at every day rollover. Leaving month 12 gives month 1 and adds one to the year modulo 4.
- R8: Control is at address 0 and reads back bits 7:4 as written, with bits 3:0 reading 0. Bit 7 (stop) halts both the divider and the chain. A nonzero mode in bits 5:4 also halts both; only mode 00 counts.
- R9: Control bit 6 (hold) freezes every count register while the divider keeps running.
- R10: If one or more steps fall due during hold, exactly one step is applied in the cycle after hold clears.
- R11: A bus write loads the addressed field at once. A step that falls due in a write cycle is applied in the next cycle. A write to address 1 also clears the divider accumulator and drops any reserved step.
- R12: Address 7 reads 0x00, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_en | input | 1 | One-cycle strobe per oscillator period |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |

## Verification
A wrong divider state shows up as the hundredths value drifting from floor(N*TICK_HZ/OSC_HZ). The drift becomes visible within one oscillator period of the missed or extra step. A corrupted carry path gives a wrong higher field immediately after a single step from a boundary value, so each rollover is checked by loading a boundary and issuing exactly one step. A lost or duplicated reserved step during hold is visible in the hundredths byte one cycle after hold clears.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int DATA_W = 8;

  typedef struct packed {
    logic [DATA_W-1:0] hs;
    logic [DATA_W-1:0] sec;
    logic [DATA_W-1:0] mins;
    logic [DATA_W-1:0] hr;
    logic [DATA_W-1:0] day;
    logic [DATA_W-1:0] mon;
  } rtc_time_t;

  // Packed BCD increment of a two-digit byte.
  function automatic logic [7:0] bcd_inc(input logic [7:0] b);
    if (b[3:0] >= 4'd9) return {b[7:4] + 4'd1, 4'd0};
    return b + 8'd1;
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  // Month length from BCD month and 2-bit year (year 0 is leap).
  function automatic logic [6:0] month_days(input logic [4:0] mon_bcd, input logic [1:0] yr);
    logic [6:0] m;
    m = bcd_to_bin({3'b000, mon_bcd});
    case (m)
      7'd2:                     return (yr == 2'd0) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:  return 7'd30;
      default:                  return 7'd31;
    endcase
  endfunction

  // Returns {day_carry, next hour byte}.
  function automatic logic [8:0] hour_next(input logic [7:0] hr);
    logic [6:0] h;
    logic [5:0] inc;
    h   = bcd_to_bin({2'b00, hr[5:0]});
    inc = 6'(bcd_inc({2'b00, hr[5:0]}));
    if (!hr[7]) begin
      if (h >= 7'd23) return {1'b1, hr[7:6], 6'h00};
      return {1'b0, hr[7:6], inc};
    end
    if (h >= 7'd12) return {1'b0, hr[7:6], 6'h01};
    if (h == 7'd11) return {hr[6], hr[7], ~hr[6], 6'h12};
    return {1'b0, hr[7:6], inc};
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int OSC_HZ  = 32768,
  parameter int TICK_HZ = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic run,
  input  logic clr,
  output logic tick,
  output logic acc_zero
);
  localparam int ACC_W = $clog2(OSC_HZ + TICK_HZ + 1);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_sum;

  assign acc_sum  = acc_q + ACC_W'(TICK_HZ);
  assign tick     = osc_en && run && !clr && (acc_sum >= ACC_W'(OSC_HZ));
  assign acc_zero = (acc_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             acc_q <= '0;
    else if (clr)           acc_q <= '0;
    else if (osc_en && run) acc_q <= tick ? acc_sum - ACC_W'(OSC_HZ) : acc_sum;
  end
endmodule

// File: rtl/rtc_step_gate.sv
module rtc_step_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic hold,
  input  logic busy,
  input  logic drop,
  output logic step,
  output logic pending
);
  logic pend_q;

  assign pending = pend_q;
  assign step    = run && !hold && !busy && (tick || pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pend_q <= 1'b0;
    else if (drop || !run) pend_q <= 1'b0;
    else if (hold || busy) pend_q <= pend_q | tick;
    else                   pend_q <= 1'b0;
  end
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output rtc_time_t         tm,
  output logic              day_carry
);
  rtc_time_t tm_q, tm_n;
  logic c_sec, c_min, c_hr, c_mon;
  logic [8:0] hres;
  logic [6:0] dim;
  logic [2:0] wd;

  assign tm = tm_q;

  always_comb begin
    tm_n  = tm_q;
    c_sec = bcd_to_bin(tm_q.hs) >= 7'd99;
    c_min = c_sec && (bcd_to_bin(tm_q.sec) >= 7'd59);
    c_hr  = c_min && (bcd_to_bin(tm_q.mins) >= 7'd59);
    hres  = hour_next(tm_q.hr);
    day_carry = c_hr && hres[8];
    dim   = month_days(tm_q.mon[4:0], tm_q.day[7:6]);
    c_mon = day_carry && (bcd_to_bin({2'b00, tm_q.day[5:0]}) >= dim);
    wd    = tm_q.mon[7:5];

    tm_n.hs = c_sec ? 8'h00 : bcd_inc(tm_q.hs);
    if (c_sec) tm_n.sec  = c_min ? 8'h00 : bcd_inc(tm_q.sec);
    if (c_min) tm_n.mins = c_hr ? 8'h00 : bcd_inc(tm_q.mins);
    if (c_hr)  tm_n.hr   = hres[7:0];
    if (day_carry) begin
      tm_n.day[5:0] = c_mon ? 6'h01 : 6'(bcd_inc({2'b00, tm_q.day[5:0]}));
      tm_n.mon[7:5] = (wd >= 3'd6) ? 3'd0 : wd + 3'd1;
    end
    if (c_mon) begin
      if (bcd_to_bin({3'b000, tm_q.mon[4:0]}) >= 7'd12) begin
        tm_n.mon[4:0] = 5'h01;
        tm_n.day[7:6] = tm_q.day[7:6] + 2'd1;
      end else begin
        tm_n.mon[4:0] = 5'(bcd_inc({3'b000, tm_q.mon[4:0]}));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tm_q <= '{hs: 8'h00, sec: 8'h00, mins: 8'h00, hr: 8'h00, day: 8'h01, mon: 8'h01};
    end else if (wr_en) begin
      case (addr)
        ADDR_W'(1): tm_q.hs   <= wdata;
        ADDR_W'(2): tm_q.sec  <= wdata;
        ADDR_W'(3): tm_q.mins <= wdata;
        ADDR_W'(4): tm_q.hr   <= wdata;
        ADDR_W'(5): tm_q.day  <= wdata;
        ADDR_W'(6): tm_q.mon  <= wdata;
        default: ;
      endcase
    end else if (step) begin
      tm_q <= tm_n;
    end
  end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_pkg::*;
#(
  parameter int OSC_HZ  = 32768,
  parameter int TICK_HZ = 100,
  parameter int ADDR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  logic [3:0] ctrl_q;
  logic stop, hold, run, hs_wr, tick, step, pending, acc_zero, day_carry;
  logic [1:0] mode;
  rtc_time_t tm;

  assign stop  = ctrl_q[3];
  assign hold  = ctrl_q[2];
  assign mode  = ctrl_q[1:0];
  assign run   = !stop && (mode == 2'b00);
  assign hs_wr = wr_en && (addr == ADDR_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              ctrl_q <= 4'h0;
    else if (wr_en && addr == ADDR_W'(0))    ctrl_q <= wdata[7:4];
  end

  rtc_prescaler #(.OSC_HZ(OSC_HZ), .TICK_HZ(TICK_HZ)) u_div (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .run(run), .clr(hs_wr),
    .tick(tick), .acc_zero(acc_zero)
  );

  rtc_step_gate u_gate (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .hold(hold),
    .busy(wr_en), .drop(hs_wr), .step(step), .pending(pending)
  );

  rtc_time_chain #(.ADDR_W(ADDR_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .step(step), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .tm(tm), .day_carry(day_carry)
  );

  always_comb begin
    case (addr)
      ADDR_W'(0): rdata = {ctrl_q, 4'h0};
      ADDR_W'(1): rdata = tm.hs;
      ADDR_W'(2): rdata = tm.sec;
      ADDR_W'(3): rdata = tm.mins;
      ADDR_W'(4): rdata = tm.hr;
      ADDR_W'(5): rdata = tm.day;
      ADDR_W'(6): rdata = tm.mon;
      default:    rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              osc_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              run,
  input logic              hold,
  input logic              tick,
  input logic              step,
  input logic              pending,
  input logic              acc_zero,
  input logic              day_carry,
  input logic [7:0]        hs,
  input logic [7:0]        sec,
  input logic [7:0]        mon
);
  AST_TICK_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (osc_en && run)); // R2
  AST_HS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && hs == 8'h99) |=> (hs == 8'h00)); // R3
  AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && day_carry && mon[7:5] == 3'd6) |=> (mon[7:5] == 3'd0)); // R7
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_en) |=> ($stable(hs) && $stable(sec))); // R8
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !wr_en) |=> ($stable(hs) && $stable(sec))); // R9
  AST_HOLD_RESERVE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && tick && !(wr_en && addr == ADDR_W'(1))) |=> pending); // R10
  AST_DIV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(1)) |=> (acc_zero && !pending)); // R11
endmodule

bind rtc_calendar_core rtc_calendar_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .wr_en(wr_en), .addr(addr),
  .run(run), .hold(hold), .tick(tick), .step(step), .pending(pending),
  .acc_zero(acc_zero), .day_carry(day_carry), .hs(tm.hs), .sec(tm.sec),
  .mon(tm.mon)
);

// File: tb/test_rtc_calendar_core.sv
module test_rtc_calendar_core;
  localparam int OSC = 5;
  localparam int TK  = 2;

  logic clk = 1'b0, rst_n = 1'b0, osc_en = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rtc_calendar_core #(.OSC_HZ(OSC), .TICK_HZ(TK), .ADDR_W(3)) i_rtc_calendar_core (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int steps_after(input int n);  // floor(n*TK/OSC)
    return (n * TK) / OSC;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); osc_en = 1'b1;
      @(negedge clk); osc_en = 1'b0;
    end
  endtask

  task automatic chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    addr = a; #1;
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s addr=%0d actual=%02h expected=%02h", req, a, rdata, exp);
    end
  endtask

  // Load a boundary, then exactly one step (hundredths write clears divider).
  task automatic one_step(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                          input logic [7:0] d, input logic [7:0] mo);
    wr(3'd2, s); wr(3'd3, m); wr(3'd4, h); wr(3'd5, d); wr(3'd6, mo);
    wr(3'd1, 8'h99);
    pulses(3);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    chk("R1", 3'd0, 8'h00); chk("R1", 3'd1, 8'h00); chk("R1", 3'd2, 8'h00);
    chk("R1", 3'd3, 8'h00); chk("R1", 3'd4, 8'h00); chk("R1", 3'd5, 8'h01);
    chk("R1", 3'd6, 8'h01);

    // R12 unused address
    wr(3'd7, 8'h5A);
    chk("R12", 3'd7, 8'h00); chk("R12", 3'd0, 8'h00); chk("R12", 3'd1, 8'h00);
    chk("R12", 3'd4, 8'h00); chk("R12", 3'd5, 8'h01); chk("R12", 3'd6, 8'h01);

    // R2 fractional divider
    wr(3'd1, 8'h00);
    pulses(10);
    chk("R2", 3'd1, to_bcd(steps_after(10)));

    // R3 hundredths sweep over a full wrap
    wr(3'd1, 8'h00);
    for (int k = 1; k <= 100; k++) begin
      pulses((5 * k + 1) / 2 - (5 * (k - 1) + 1) / 2);
      chk("R3", 3'd1, to_bcd(k % 100));
    end
    chk("R3", 3'd2, 8'h01);

    // R4 seconds and minutes
    one_step(8'h29, 8'h14, 8'h05, 8'h01, 8'h01);
    chk("R4", 3'd2, 8'h30); chk("R4", 3'd3, 8'h14);
    one_step(8'h59, 8'h59, 8'h05, 8'h01, 8'h01);
    chk("R4", 3'd2, 8'h00); chk("R4", 3'd3, 8'h00); chk("R4", 3'd4, 8'h06);

    // R5 24-hour wrap, R7 Feb 28 non-leap -> Mar 1
    one_step(8'h59, 8'h59, 8'h23, 8'h68, 8'hC2);
    chk("R5", 3'd4, 8'h00); chk("R7", 3'd5, 8'h41); chk("R7", 3'd6, 8'h03);
    // R7 leap year Feb 28 -> 29 -> Mar 1
    one_step(8'h59, 8'h59, 8'h23, 8'h28, 8'h42);
    chk("R7", 3'd5, 8'h29); chk("R7", 3'd6, 8'h62);
    one_step(8'h59, 8'h59, 8'h23, 8'h29, 8'h62);
    chk("R7", 3'd5, 8'h01); chk("R7", 3'd6, 8'h83);
    // R7 30-day month and year wrap on Dec 31
    one_step(8'h59, 8'h59, 8'h23, 8'h70, 8'h04);
    chk("R7", 3'd5, 8'h41); chk("R7", 3'd6, 8'h25);
    one_step(8'h59, 8'h59, 8'h23, 8'hF1, 8'hB2);
    chk("R7", 3'd5, 8'h01); chk("R7", 3'd6, 8'hC1);

    // R6 12-hour sequence
    one_step(8'h59, 8'h59, 8'h91, 8'h01, 8'h01);
    chk("R6", 3'd4, 8'hD2); chk("R6", 3'd5, 8'h01);
    one_step(8'h59, 8'h59, 8'hD2, 8'h01, 8'h01);
    chk("R6", 3'd4, 8'hC1);
    one_step(8'h59, 8'h59, 8'hD1, 8'h01, 8'h01);
    chk("R6", 3'd4, 8'h92); chk("R6", 3'd5, 8'h02); chk("R6", 3'd6, 8'h21);

    // R8 stop, nonzero mode, control readback
    wr(3'd1, 8'h00); wr(3'd0, 8'h80);
    pulses(10);
    chk("R8", 3'd1, 8'h00);
    wr(3'd0, 8'h20);
    pulses(10);
    chk("R8", 3'd1, 8'h00);
    wr(3'd0, 8'hFF);
    chk("R8", 3'd0, 8'hF0);

    // R9 hold freezes, R10 one reserved step on release
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd0, 8'h40);
    pulses(10);
    chk("R9", 3'd1, 8'h00);
    wr(3'd0, 8'h00);
    @(negedge clk);
    chk("R10", 3'd1, 8'h01);
    @(negedge clk);
    chk("R10", 3'd1, 8'h01);

    // R11 hundredths write clears the divider
    wr(3'd1, 8'h00);
    pulses(2);
    wr(3'd1, 8'h50);
    pulses(2);
    chk("R11", 3'd1, 8'h50);
    pulses(1);
    chk("R11", 3'd1, 8'h51);
    wr(3'd3, 8'h42);
    chk("R11", 3'd3, 8'h42);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    done = 1;
    $finish;
  end
endmodule